// File: doc/BRIEF.md
# Cache Tag ECC Checker and Error Logger

This block sits next to the tag store of an 8-way set-associative cache. On every lookup the tag store presents the addressed index together with the stored codeword of every way, plus the hit flag and hit way. The block checks all ways at once with a SEC/DED code. It hands back the corrected codeword of the selected way in the same cycle so the array can write it back. It also keeps one software-visible status register that records what went wrong and where.

Each codeword holds DATA_W protected bits (valid, dirty, lock and tag bits; 19 by default) in bits [DATA_W-1:0]. Above them sit a Hamming check field and an overall parity bit on top. Data bit k sits at the k-th Hamming position that is not a power of two (3, 5, 6, 7, 9, ...). The check field is the XOR of the positions of all set data bits. The parity bit makes the whole codeword even. The 6-bit syndrome is {parity mismatch, recomputed check XOR stored check}.

Probes arrive on a valid/ready stream, and corrected words leave on another. The two are joined combinationally: `probe_ready` follows `fix_ready`. A probe is consumed, and only then logged, in a cycle where both `probe_valid` and `probe_ready` are high. While `fix_ready` is low the probe source must hold its inputs.

Top module: `tag_ecc_logger`

## Requirements
- R1: After reset, `reg_rdata` reads 0 and `irq` is low.
- R2: A consumed probe in which any way has a single-bit error sets the single-error flag (bit 3) on the next clock.
- R3: A consumed probe in which any way has a double-bit error sets the double-error flag (bit 4) on the next clock.
- R4: In the same cycle as the probe, `fix_word` carries the codeword of way `probe_way`. A single-bit error in that word is corrected and the check bits are regenerated. A double-bit word is passed through unchanged.
- R5: The capture holds the syndrome in bits [10:5], the way in bits [13:11] and the index in bits [23:14]. Syndrome and way are taken from the hit way only when the hit way itself has the captured error class. Otherwise both are 0.
- R6: A double-bit error overwrites a previously captured single-bit error. While either flag is set, a further single-bit error leaves the capture alone. While the double-error flag is set, a further double-bit error leaves the capture alone.
- R7: Writing 1 to bit 3 or bit 4 clears that flag. Once both flags are clear, the next error is captured afresh.
- R8: `irq` is high exactly when (bit 3 and enable bit 1) or (bit 4 and enable bit 2).
- R9: With the ECC enable (bit 0) at 0, no flag rises and `fix_word` equals the raw word of the selected way.
- R10: `fix_valid` follows `probe_valid` and `probe_ready` follows `fix_ready`. A probe presented while `fix_ready` is low changes no status.
- R11: Every register write loads bits [2:0] (ECC enable, single-error and double-error interrupt enables), and they read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| probe_valid | input | 1 | Probe present |
| probe_ready | output | 1 | Probe accepted this cycle |
| probe_index | input | IDX_W | Cacheline index of the probe |
| probe_words | input | WAYS*CW_W | Stored codewords; way w at [w*CW_W +: CW_W] |
| probe_hit | input | 1 | Lookup hit |
| probe_way | input | WAY_W | Hit way (selects `fix_word`) |
| fix_valid | output | 1 | Corrected word present |
| fix_ready | input | 1 | Write-back side can take the word |
| fix_word | output | CW_W | Corrected codeword of the selected way |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 32 | Write data (bits [2:0] load, bits 3 and 4 clear on 1) |
| reg_rdata | output | 32 | Status register contents |
| irq | output | 1 | Error interrupt |

## Verification
The hardest states to reach are the capture-lock cases. A second error must arrive while an earlier one is still held, and the capture has to be shown to keep or replace its contents. The stimulus builds them in order. First comes a single-bit error in the hit way. Then a second single-bit error elsewhere, which must not disturb the capture. Then a double-bit error confined to a non-hit way, which must overwrite with a zero syndrome. Then a further double-bit error, which must be ignored. Every error is made by flipping chosen bits of a clean word that the bench encodes itself, so each expected syndrome follows from the flipped bit positions alone.

// File: rtl/tag_ecc_pkg.sv
package tag_ecc_pkg;
  localparam int DEF_DATA_W = 19;
  localparam int DEF_WAYS   = 8;
  localparam int DEF_IDX_W  = 10;
  localparam int REG_W      = 32;

  // Smallest Hamming field r with 2**r >= dw + r + 1.
  function automatic int ham_width(input int dw);
    int r;
    r = 1;
    while ((1 << r) < dw + r + 1) r++;
    return r;
  endfunction
endpackage

// File: rtl/tag_ecc_way_chk.sv
module tag_ecc_way_chk #(
  parameter int DATA_W = 19,
  parameter int HAM_W  = 5
) (
  input  logic                      en_i,
  input  logic [DATA_W+HAM_W:0]     cw_i,
  output logic [HAM_W:0]            syn_o,
  output logic                      sec_o,
  output logic                      ded_o,
  output logic [DATA_W+HAM_W:0]     fix_o
);
  localparam int CW_W = DATA_W + HAM_W + 1;
  localparam int NPOS = 1 << HAM_W;

  function automatic int last_pos();
    int k;
    int lp;
    k = 0;
    lp = 0;
    for (int p = 1; p < NPOS; p++) begin
      if ((p & (p - 1)) != 0 && k < DATA_W) begin
        lp = p;
        k++;
      end
    end
    return lp;
  endfunction

  localparam int LAST_POS = last_pos();

  function automatic logic [HAM_W-1:0] ham(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    int k;
    h = '0;
    k = 0;
    for (int p = 1; p < NPOS; p++) begin
      if ((p & (p - 1)) != 0 && k < DATA_W) begin
        if (d[k]) h = h ^ p[HAM_W-1:0];
        k++;
      end
    end
    return h;
  endfunction

  function automatic logic [CW_W-1:0] enc(input logic [DATA_W-1:0] d);
    logic [HAM_W-1:0] h;
    h = ham(d);
    return {(^d) ^ (^h), h, d};
  endfunction

  logic [DATA_W-1:0] data, dfix;
  logic [HAM_W-1:0]  s_low;
  logic              s_hi, sec_raw, ded_raw;

  always_comb begin
    data    = cw_i[DATA_W-1:0];
    s_low   = ham(data) ^ cw_i[DATA_W +: HAM_W];
    s_hi    = ^cw_i;
    sec_raw = s_hi && (32'(s_low) <= LAST_POS);
    ded_raw = (s_hi || (s_low != '0)) && !sec_raw;
  end

  // Flip the data bit whose Hamming position equals the syndrome.
  always_comb begin
    int k;
    dfix = data;
    k = 0;
    for (int p = 1; p < NPOS; p++) begin
      if ((p & (p - 1)) != 0 && k < DATA_W) begin
        if (sec_raw && (p[HAM_W-1:0] == s_low)) dfix[k] = ~data[k];
        k++;
      end
    end
  end

  assign sec_o = en_i & sec_raw;
  assign ded_o = en_i & ded_raw;
  assign syn_o = en_i ? {s_hi, s_low} : '0;
  assign fix_o = (en_i && sec_raw) ? enc(dfix) : cw_i;
endmodule

// File: rtl/tag_ecc_status.sv
module tag_ecc_status #(
  parameter int CHK_W = 6,
  parameter int WAY_W = 3,
  parameter int IDX_W = 10,
  parameter int REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             any_sec_i,
  input  logic             any_ded_i,
  input  logic             hit_sec_i,
  input  logic             hit_ded_i,
  input  logic [CHK_W-1:0] hit_syn_i,
  input  logic [WAY_W-1:0] hit_way_i,
  input  logic [IDX_W-1:0] index_i,
  input  logic             wr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             ecc_en_o,
  output logic             irq_o
);
  localparam int B_EN  = 0;
  localparam int B_SIE = 1;
  localparam int B_DIE = 2;
  localparam int B_SEC = 3;
  localparam int B_DED = 4;
  localparam int F_SYN = 5;
  localparam int F_WAY = F_SYN + CHK_W;
  localparam int F_IDX = F_WAY + WAY_W;

  logic             en_q, sie_q, die_q, sec_q, ded_q;
  logic [CHK_W-1:0] syn_q;
  logic [WAY_W-1:0] way_q;
  logic [IDX_W-1:0] idx_q;
  logic             ev_sec, ev_ded, take_ded, take_sec;

  assign ev_sec   = fire_i & any_sec_i;
  assign ev_ded   = fire_i & any_ded_i;
  assign take_ded = ev_ded & ~ded_q;
  assign take_sec = ev_sec & ~ev_ded & ~sec_q & ~ded_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      sie_q <= 1'b0;
      die_q <= 1'b0;
      sec_q <= 1'b0;
      ded_q <= 1'b0;
      syn_q <= '0;
      way_q <= '0;
      idx_q <= '0;
    end else begin
      if (wr_i) begin
        en_q  <= wdata_i[B_EN];
        sie_q <= wdata_i[B_SIE];
        die_q <= wdata_i[B_DIE];
      end
      sec_q <= (sec_q & ~(wr_i & wdata_i[B_SEC])) | ev_sec;
      ded_q <= (ded_q & ~(wr_i & wdata_i[B_DED])) | ev_ded;
      if (take_ded) begin
        syn_q <= hit_ded_i ? hit_syn_i : '0;
        way_q <= hit_ded_i ? hit_way_i : '0;
        idx_q <= index_i;
      end else if (take_sec) begin
        syn_q <= hit_sec_i ? hit_syn_i : '0;
        way_q <= hit_sec_i ? hit_way_i : '0;
        idx_q <= index_i;
      end
    end
  end

  always_comb begin
    rdata_o               = '0;
    rdata_o[B_EN]         = en_q;
    rdata_o[B_SIE]        = sie_q;
    rdata_o[B_DIE]        = die_q;
    rdata_o[B_SEC]        = sec_q;
    rdata_o[B_DED]        = ded_q;
    rdata_o[F_SYN +: CHK_W] = syn_q;
    rdata_o[F_WAY +: WAY_W] = way_q;
    rdata_o[F_IDX +: IDX_W] = idx_q;
  end

  assign ecc_en_o = en_q;
  assign irq_o    = (sec_q & sie_q) | (ded_q & die_q);
endmodule

// File: rtl/tag_ecc_logger.sv
module tag_ecc_logger #(
  parameter int DATA_W = tag_ecc_pkg::DEF_DATA_W,
  parameter int WAYS   = tag_ecc_pkg::DEF_WAYS,
  parameter int IDX_W  = tag_ecc_pkg::DEF_IDX_W,
  parameter int HAM_W  = tag_ecc_pkg::ham_width(DATA_W),
  parameter int CW_W   = DATA_W + HAM_W + 1,
  parameter int WAY_W  = $clog2(WAYS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 probe_valid,
  output logic                 probe_ready,
  input  logic [IDX_W-1:0]     probe_index,
  input  logic [WAYS*CW_W-1:0] probe_words,
  input  logic                 probe_hit,
  input  logic [WAY_W-1:0]     probe_way,
  output logic                 fix_valid,
  input  logic                 fix_ready,
  output logic [CW_W-1:0]      fix_word,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  output logic [31:0]          reg_rdata,
  output logic                 irq
);
  localparam int CHK_W = HAM_W + 1;

  logic             ecc_en;
  logic [WAYS-1:0]  sec_w, ded_w;
  logic [CHK_W-1:0] syn_w [WAYS];
  logic [CW_W-1:0]  fix_w [WAYS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    tag_ecc_way_chk #(.DATA_W(DATA_W), .HAM_W(HAM_W)) u_chk (
      .en_i  (ecc_en),
      .cw_i  (probe_words[w*CW_W +: CW_W]),
      .syn_o (syn_w[w]),
      .sec_o (sec_w[w]),
      .ded_o (ded_w[w]),
      .fix_o (fix_w[w])
    );
  end

  logic fire;
  assign probe_ready = fix_ready;
  assign fix_valid   = probe_valid;
  assign fire        = probe_valid & fix_ready;
  assign fix_word    = fix_w[probe_way];

  tag_ecc_status #(
    .CHK_W(CHK_W), .WAY_W(WAY_W), .IDX_W(IDX_W), .REG_W(tag_ecc_pkg::REG_W)
  ) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .any_sec_i (|sec_w),
    .any_ded_i (|ded_w),
    .hit_sec_i (probe_hit & sec_w[probe_way]),
    .hit_ded_i (probe_hit & ded_w[probe_way]),
    .hit_syn_i (syn_w[probe_way]),
    .hit_way_i (probe_way),
    .index_i   (probe_index),
    .wr_i      (reg_wr),
    .wdata_i   (reg_wdata),
    .rdata_o   (reg_rdata),
    .ecc_en_o  (ecc_en),
    .irq_o     (irq)
  );
endmodule

// File: rtl/tag_ecc_logger_chk.sv
module tag_ecc_logger_chk #(
  parameter int WAYS  = 8,
  parameter int IDX_W = 10,
  parameter int CW_W  = 25,
  parameter int WAY_W = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 probe_valid,
  input logic                 probe_ready,
  input logic [IDX_W-1:0]     probe_index,
  input logic [WAYS*CW_W-1:0] probe_words,
  input logic                 probe_hit,
  input logic [WAY_W-1:0]     probe_way,
  input logic                 fix_valid,
  input logic                 fix_ready,
  input logic [CW_W-1:0]      fix_word,
  input logic                 reg_wr,
  input logic [31:0]          reg_wdata,
  input logic [31:0]          reg_rdata,
  input logic                 irq
);
  logic fire;
  assign fire = probe_valid & probe_ready;

  assert_sec_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[3] && !(reg_wr && reg_wdata[3]) |=> reg_rdata[3]);

  assert_ded_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] && !(reg_wr && reg_wdata[4]) |=> reg_rdata[4]);

  assert_ded_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[4] && !reg_wr |=> $stable(reg_rdata[31:5]));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_wdata[3] && !fire |=> !reg_rdata[3]);

  assert_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == ((reg_rdata[3] & reg_rdata[1]) | (reg_rdata[4] & reg_rdata[2])));

  assert_off_raw_R9: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid && !reg_rdata[0] |-> fix_word == probe_words[probe_way*CW_W +: CW_W]);

  assert_off_noflag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rdata[0] && !reg_wr |=> !$rose(reg_rdata[3]) && !$rose(reg_rdata[4]));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !fire && !reg_wr |=> $stable(reg_rdata));

  assert_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    fix_valid == probe_valid);
endmodule

bind tag_ecc_logger tag_ecc_logger_chk #(
  .WAYS(WAYS), .IDX_W(IDX_W), .CW_W(CW_W), .WAY_W(WAY_W)
) u_logger_chk (.*);

// File: tb/tb_tag_ecc_logger.sv
`timescale 1ns/100ps
module tb_tag_ecc_logger;
  localparam int CW = 25;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic probe_valid = 1'b0;
  logic probe_ready;
  logic [9:0] probe_index = '0;
  logic [NW*CW-1:0] probe_words = '0;
  logic probe_hit = 1'b0;
  logic [2:0] probe_way = '0;
  logic fix_valid;
  logic fix_ready = 1'b1;
  logic [CW-1:0] fix_word;
  logic reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic irq;

  int total = 0;
  int bad = 0;
  logic [CW-1:0] exp_q[$];
  logic [CW-1:0] words[NW];

  always #2 clk = ~clk;

  tag_ecc_logger dut (.*);

  function automatic int bpos(input int k);
    int p, n;
    p = 2;
    n = -1;
    while (n < k) begin
      p++;
      if ((p & (p - 1)) != 0) n++;
    end
    return p;
  endfunction

  function automatic logic [CW-1:0] benc(input logic [18:0] d);
    logic [4:0] h;
    for (int j = 0; j < 5; j++) begin
      h[j] = 1'b0;
      for (int k = 0; k < 19; k++)
        if (d[k] && ((bpos(k) >> j) & 1) == 1) h[j] = ~h[j];
    end
    return {^{d, h}, h, d};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_clean();
    for (int w = 0; w < NW; w++) words[w] = benc(19'h2A5C3 ^ 19'(w * 4369));
  endtask

  task automatic send(input logic [9:0] idx, input bit hit, input logic [2:0] way,
                      input logic [CW-1:0] expw);
    @(negedge clk);
    for (int w = 0; w < NW; w++) probe_words[w*CW +: CW] = words[w];
    probe_index = idx;
    probe_hit   = hit;
    probe_way   = way;
    probe_valid = 1'b1;
    exp_q.push_back(expw);
    @(negedge clk);
    probe_valid = 1'b0;
    #1;
  endtask

  task automatic wr(input logic [31:0] v);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  task automatic cap(input string req, input logic [5:0] syn, input logic [2:0] way,
                     input logic [9:0] idx);
    check({req, " syndrome"}, 32'(reg_rdata[10:5]), 32'(syn));
    check({req, " way"}, 32'(reg_rdata[13:11]), 32'(way));
    check({req, " index"}, 32'(reg_rdata[23:14]), 32'(idx));
  endtask

  // Monitor: compare every consumed probe's corrected word with the queue head.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (probe_valid && probe_ready) begin
        if (exp_q.size() == 0) check("R4 unexpected word", 32'(fix_word), 32'h0);
        else check("R4 fix_word", 32'(fix_word), 32'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #(4 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [CW-1:0] clean, raw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 rdata after reset", reg_rdata, 32'h0);
    check("R1 irq after reset", 32'(irq), 32'h0);

    wr(32'h7);
    check("R11 control readback", reg_rdata[2:0], 32'h7);

    fill_clean();
    send(10'h001, 1'b1, 3'd1, words[1]);
    check("R2 clean probe no flags", 32'(reg_rdata[4:3]), 32'h0);

    // single-bit error in hit way 5, data bit 0 (position 3)
    fill_clean();
    clean = words[5];
    words[5][0] = ~words[5][0];
    send(10'h155, 1'b1, 3'd5, clean);
    check("R2 sec flag", 32'(reg_rdata[3]), 32'h1);
    cap("R5 hit-way sec", 6'h23, 3'd5, 10'h155);
    check("R8 irq on sec", 32'(irq), 32'h1);

    // second single-bit error must not disturb the capture
    fill_clean();
    clean = words[2];
    words[2][7] = ~words[2][7];
    send(10'h0AA, 1'b1, 3'd2, clean);
    cap("R6 sec keeps capture", 6'h23, 3'd5, 10'h155);

    // double-bit error only in non-hit way 6 overwrites the sec capture
    fill_clean();
    words[6][3] = ~words[6][3];
    words[6][9] = ~words[6][9];
    send(10'h3C3, 1'b1, 3'd1, words[1]);
    check("R3 ded flag", 32'(reg_rdata[4]), 32'h1);
    cap("R6 ded overwrites, R5 non-hit zero", 6'h00, 3'd0, 10'h3C3);

    // another double-bit error in the hit way is not captured
    fill_clean();
    words[3][0] = ~words[3][0];
    words[3][1] = ~words[3][1];
    send(10'h011, 1'b1, 3'd3, words[3]);
    cap("R6 ded keeps capture", 6'h00, 3'd0, 10'h3C3);

    // drop ded enable and clear sec: irq must fall while ded is still set
    wr(32'h3 | 32'h8);
    check("R7 sec cleared", 32'(reg_rdata[4:3]), 32'h2);
    check("R8 irq masked", 32'(irq), 32'h0);

    // clear ded, then a sec in hit way 7 on check bit 2 is captured afresh
    wr(32'h3 | 32'h10);
    check("R7 both clear", 32'(reg_rdata[4:3]), 32'h0);
    fill_clean();
    clean = words[7];
    words[7][21] = ~words[7][21];
    send(10'h200, 1'b1, 3'd7, clean);
    cap("R7 unlocked capture", 6'h24, 3'd7, 10'h200);

    // ded in hit way 4 (data bits 0,1 -> positions 3,5): word passes raw
    fill_clean();
    words[4][0] = ~words[4][0];
    words[4][1] = ~words[4][1];
    send(10'h2F0, 1'b1, 3'd4, words[4]);
    cap("R6 ded over sec in hit way", 6'h06, 3'd4, 10'h2F0);

    // back-pressure: nothing logged while fix_ready is low
    wr(32'h7 | 32'h18);
    fill_clean();
    words[0][4] = ~words[0][4];
    @(negedge clk);
    fix_ready = 1'b0;
    for (int w = 0; w < NW; w++) probe_words[w*CW +: CW] = words[w];
    probe_way = 3'd0;
    probe_hit = 1'b1;
    probe_valid = 1'b1;
    #1;
    check("R10 fix_valid follows", 32'(fix_valid), 32'h1);
    check("R10 ready follows", 32'(probe_ready), 32'h0);
    @(negedge clk);
    probe_valid = 1'b0;
    fix_ready = 1'b1;
    #1;
    check("R10 stall no status", 32'(reg_rdata[4:3]), 32'h0);

    // single-bit error on the parity bit of hit way 6
    fill_clean();
    clean = words[6];
    words[6][24] = ~words[6][24];
    send(10'h0F0, 1'b1, 3'd6, clean);
    cap("R5 parity-bit syndrome", 6'h20, 3'd6, 10'h0F0);

    // sec only in non-hit way 2 while way 1 hits
    wr(32'h7 | 32'h18);
    fill_clean();
    words[2][5] = ~words[2][5];
    send(10'h123, 1'b1, 3'd1, words[1]);
    check("R2 non-hit sec flag", 32'(reg_rdata[3]), 32'h1);
    cap("R5 non-hit sec zero", 6'h00, 3'd0, 10'h123);

    // ECC disabled: raw word out, no flags
    wr(32'h6 | 32'h18);
    fill_clean();
    raw = words[3];
    raw[2] = ~raw[2];
    words[3] = raw;
    send(10'h050, 1'b1, 3'd3, raw);
    check("R9 disabled no flags", 32'(reg_rdata[4:3]), 32'h0);

    repeat (2) @(negedge clk);
    check("R4 queue drained", 32'(exp_q.size()), 32'h0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule